// File: doc/BRIEF.md
# Dual Serial Game Controller Reader

This block lets a processor read the button state of two game controllers one bit at a time. Each controller presents its buttons as a 24-bit parallel word. The block maps two adjacent byte addresses onto these words, one address for each controller. Each read at a controller's address returns the bit chosen by that controller's own cursor in data bit 0, with a fixed marker bit set. The cursor then moves to the next position.

A write to the first controller address is the strobe. The block keeps bit 0 of the last strobe value. When a new strobe write raises that bit from 0 to 1, both cursors return to position 0, so software can restart the bit sequence of both controllers together. The read data is registered and appears one clock after the read request.

Top module: `dual_pad_reader`

## Requirements
- R1: After reset both cursors are 0, the stored strobe bit is 0 and the read data output is 0x00.
- R2: A read at address 0x4016 returns, one clock later, a byte with bit 0 equal to bit[cursor 0] of controller word 0, bit 6 set to 1 and every other bit 0.
- R3: A read at address 0x4017 returns the same byte shape, built from controller word 1 at cursor 1.
- R4: Each read at a controller address moves that controller's cursor forward by one. After position 23 the cursor goes back to 0, so the 25th read of a sequence returns word bit 0 again.
- R5: A read at one controller address leaves the other controller's cursor where it was.
- R6: A write to 0x4016 with data bit 0 = 1, when the stored strobe bit is 0, sets both cursors to 0.
- R7: A write to 0x4016 with data bit 0 = 1, when the stored strobe bit is already 1, leaves both cursors as they were.
- R8: A write to 0x4016 with data bit 0 = 0 leaves the cursors as they were and stores 0, so the next write of 1 restarts both cursors.
- R9: A read at any other address returns 0x00 one clock later and leaves both cursors as they were.
- R10: Writes to any address other than 0x4016 (0x4017 included) change neither the cursors nor the stored strobe bit.
- R11: The read data output keeps its value in every cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Processor byte address |
| cpu_rd | input | 1 | Read request, one cycle per read |
| cpu_wr | input | 1 | Write request, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| pad_word | input | 2x24 | Parallel button words, element k for controller k |
| cpu_rdata | output | 8 | Registered read data, valid one clock after cpu_rd |

## Verification
The properties assume that read and write requests are never asserted in the same cycle. They also assume that each request lasts exactly one clock, so that every request counts as one access. The stimulus drives all requests from tasks that raise a single strobe for one cycle on a falling edge and lower it on the next falling edge. The assertions are checked only after the internally synchronised reset has been released, and the bench waits several clocks after deasserting reset before it issues its first access.

// File: rtl/pad_rd_pkg.sv
`timescale 1ns/1ps
package pad_rd_pkg;

  // Kind of processor access seen in a cycle
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_PAD  = 2'd1,
    ACC_MISS = 2'd2
  } acc_kind_e;

  // Advance a cursor with wrap at a given limit
  function automatic int unsigned cursor_step(input int unsigned cur, input int unsigned limit);
    return (cur == limit - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/pad_rst_sync.sv
`timescale 1ns/1ps
module pad_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pad_strobe_ctl.sv
`timescale 1ns/1ps
module pad_strobe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic restart,
  output logic level
);
  logic level_q, level_d, level_en;

  always_comb begin
    level_en = wr_en;
    level_d  = wr_bit;
    restart  = wr_en && wr_bit && !level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= 1'b0;
    else if (level_en) level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/pad_bit_cursor.sv
`timescale 1ns/1ps
module pad_bit_cursor #(
  parameter int unsigned LATCH_W = 24,
  localparam int unsigned IDX_W = $clog2(LATCH_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               restart,
  input  logic [LATCH_W-1:0] word,
  output logic               bit_o,
  output logic [IDX_W-1:0]   idx_o
);
  import pad_rd_pkg::*;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = adv || restart;
    if (restart) idx_d = '0;
    else         idx_d = IDX_W'(cursor_step(int'(idx_q), LATCH_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign bit_o = word[idx_q];
  assign idx_o = idx_q;
endmodule

// File: rtl/dual_pad_reader.sv
`timescale 1ns/1ps
module dual_pad_reader #(
  parameter int unsigned        ADDR_W    = 16,
  parameter int unsigned        DATA_W    = 8,
  parameter int unsigned        LATCH_W   = 24,
  parameter int unsigned        NPORTS    = 2,
  parameter logic [ADDR_W-1:0]  PORT_BASE = 16'h4016,
  parameter int unsigned        MARK_BIT  = 6,
  localparam int unsigned       IDX_W     = $clog2(LATCH_W)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic                            cpu_rd,
  input  logic                            cpu_wr,
  input  logic [DATA_W-1:0]               cpu_wdata,
  input  logic [NPORTS-1:0][LATCH_W-1:0]  pad_word,
  output logic [DATA_W-1:0]               cpu_rdata
);
  import pad_rd_pkg::*;

  logic                         rst_sync_n;
  logic                         strobe_hit;
  logic                         restart;
  logic                         strobe_level;
  logic [NPORTS-1:0]            rd_hit;
  logic [NPORTS-1:0]            port_bit;
  logic [NPORTS-1:0][IDX_W-1:0] cur_idx;
  logic                         sel_bit;
  acc_kind_e                    acc_kind;
  logic [DATA_W-1:0]            rdata_q, rdata_d;
  logic                         rdata_en;

  pad_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign strobe_hit = cpu_wr && (cpu_addr == PORT_BASE);

  pad_strobe_ctl u_stb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (strobe_hit),
    .wr_bit  (cpu_wdata[0]),
    .restart (restart),
    .level   (strobe_level)
  );

  for (genvar k = 0; k < NPORTS; k++) begin : g_port
    assign rd_hit[k] = cpu_rd && (cpu_addr == ADDR_W'(PORT_BASE + ADDR_W'(k)));

    pad_bit_cursor #(.LATCH_W(LATCH_W)) u_cur (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .adv     (rd_hit[k]),
      .restart (restart),
      .word    (pad_word[k]),
      .bit_o   (port_bit[k]),
      .idx_o   (cur_idx[k])
    );
  end

  always_comb begin
    sel_bit = |(rd_hit & port_bit);
    if (!cpu_rd)       acc_kind = ACC_IDLE;
    else if (|rd_hit)  acc_kind = ACC_PAD;
    else               acc_kind = ACC_MISS;
  end

  always_comb begin
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    case (acc_kind)
      ACC_PAD: begin
        rdata_en          = 1'b1;
        rdata_d           = '0;
        rdata_d[0]        = sel_bit;
        rdata_d[MARK_BIT] = 1'b1;
      end
      ACC_MISS: begin
        rdata_en = 1'b1;
        rdata_d  = '0;
      end
      default: begin
        rdata_en = 1'b0;
        rdata_d  = rdata_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dual_pad_reader_chk.sv
`timescale 1ns/1ps
module dual_pad_reader_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       LATCH_W   = 24,
  parameter int unsigned       NPORTS    = 2,
  parameter logic [ADDR_W-1:0] PORT_BASE = 16'h4016,
  parameter int unsigned       MARK_BIT  = 6,
  localparam int unsigned      IDX_W     = $clog2(LATCH_W)
) (
  input logic                            clk,
  input logic                            rst_sync_n,
  input logic [ADDR_W-1:0]               cpu_addr,
  input logic                            cpu_rd,
  input logic                            cpu_wr,
  input logic [DATA_W-1:0]               cpu_wdata,
  input logic [DATA_W-1:0]               cpu_rdata,
  input logic [NPORTS-1:0][IDX_W-1:0]    cur_idx,
  input logic                            strobe_level
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'((1 << MARK_BIT) | 1);

  logic pad_addr, strobe_addr;
  assign pad_addr    = (cpu_addr >= PORT_BASE) && (cpu_addr < ADDR_W'(PORT_BASE + ADDR_W'(NPORTS)));
  assign strobe_addr = (cpu_addr == PORT_BASE);

  a_in_no_overlap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cpu_rd && cpu_wr));

  // R2 / R3: reply shape
  a_r2_reply_shape: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd && pad_addr) |=> (cpu_rdata[MARK_BIT] && ((cpu_rdata & ~KEEP) == '0)));

  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd && !pad_addr) |=> (cpu_rdata == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cpu_rd |=> $stable(cpu_rdata));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_wr && strobe_addr && cpu_wdata[0] && !strobe_level) |=> (cur_idx == '0));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_wr && strobe_addr && cpu_wdata[0] && strobe_level) |=> $stable(cur_idx));

  a_r10_other_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cpu_rd && !(cpu_wr && strobe_addr)) |=> ($stable(cur_idx) && $stable(strobe_level)));

  for (genvar k = 0; k < NPORTS; k++) begin : g_chk
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
      cur_idx[k] < IDX_W'(LATCH_W));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cpu_rd && (cpu_addr == ADDR_W'(PORT_BASE + ADDR_W'(k))) && (cur_idx[k] == IDX_W'(LATCH_W - 1)))
      |=> (cur_idx[k] == '0));

    a_r5_other_port: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cpu_rd && (cpu_addr != ADDR_W'(PORT_BASE + ADDR_W'(k)))) |=> $stable(cur_idx[k]));
  end
endmodule

bind dual_pad_reader dual_pad_reader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATCH_W(LATCH_W),
  .NPORTS(NPORTS), .PORT_BASE(PORT_BASE), .MARK_BIT(MARK_BIT)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cpu_addr     (cpu_addr),
  .cpu_rd       (cpu_rd),
  .cpu_wr       (cpu_wr),
  .cpu_wdata    (cpu_wdata),
  .cpu_rdata    (cpu_rdata),
  .cur_idx      (cur_idx),
  .strobe_level (strobe_level)
);

// File: tb/tb_dual_pad_reader.sv
`timescale 1ns/1ps
module tb_dual_pad_reader;
  localparam logic [15:0] A0 = 16'h4016;
  localparam logic [15:0] A1 = 16'h4017;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       cpu_addr;
  logic              cpu_rd, cpu_wr;
  logic [7:0]        cpu_wdata;
  logic [1:0][23:0]  pad_word;
  logic [7:0]        cpu_rdata;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int exp_idx [2];
  bit exp_stb;

  always #2.5 clk = ~clk;

  dual_pad_reader dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .pad_word(pad_word),
    .cpu_rdata(cpu_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // expected byte for a read at addr, updating the model cursor
  function automatic logic [7:0] model_read(input logic [15:0] addr);
    logic [7:0] r;
    if (addr == A0 || addr == A1) begin
      int k = (addr == A0) ? 0 : 1;
      r = 8'h40 | {7'd0, pad_word[k][exp_idx[k]]};
      exp_idx[k] = (exp_idx[k] == 23) ? 0 : exp_idx[k] + 1;
    end else begin
      r = 8'h00;
    end
    return r;
  endfunction

  task automatic rd_chk(input logic [15:0] addr, input string req);
    logic [7:0] e;
    @(negedge clk);
    cpu_addr = addr; cpu_rd = 1'b1;
    e = model_read(addr);
    @(negedge clk);
    cpu_rd = 1'b0;
    check(req, cpu_rdata, e);
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = addr; cpu_wdata = d; cpu_wr = 1'b1;
    if (addr == A0) begin
      if (!exp_stb && d[0]) begin exp_idx[0] = 0; exp_idx[1] = 0; end
      exp_stb = d[0];
    end
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rdata after reset", cpu_rdata, 8'h00);
    rd_chk(A0, "R1 port0 cursor at 0");
    rd_chk(A1, "R1 port1 cursor at 0");
  endtask

  task automatic t_port0_full;
    wr(A0, 8'h00); wr(A0, 8'h01);
    for (int i = 0; i < 24; i++) rd_chk(A0, "R2 port0 sequence");
    rd_chk(A0, "R4 port0 wrap to bit 0");
    rd_chk(A0, "R4 port0 after wrap");
  endtask

  task automatic t_port1_full;
    wr(A0, 8'h00); wr(A0, 8'h01);
    for (int i = 0; i < 30; i++) rd_chk(A1, "R3 port1 sequence");
    rd_chk(A0, "R5 port0 unaffected by port1 reads");
    pad_word[1] = 24'h0F_F0_3C;
    for (int i = 0; i < 5; i++) rd_chk(A1, "R3 port1 new word");
  endtask

  task automatic t_strobe;
    wr(A0, 8'h00);
    for (int i = 0; i < 5; i++) rd_chk(A0, "R6 advance");
    wr(A0, 8'h01);
    rd_chk(A0, "R6 restart port0");
    rd_chk(A1, "R6 restart port1");
    rd_chk(A0, "R7 setup");
    wr(A0, 8'hFF);
    rd_chk(A0, "R7 repeated 1 keeps cursor");
    wr(A0, 8'h02);
    rd_chk(A0, "R8 write 0 keeps cursor");
    wr(A0, 8'h01);
    rd_chk(A0, "R8 rising edge restarts");
  endtask

  task automatic t_other;
    wr(A0, 8'h00);
    rd_chk(A0, "R9 setup");
    rd_chk(16'h4018, "R9 miss above");
    rd_chk(16'h0016, "R9 miss low");
    rd_chk(A0, "R9 cursor unchanged");
    wr(A1, 8'h01);
    wr(16'h2000, 8'h01);
    rd_chk(A0, "R10 write elsewhere keeps cursor");
    wr(A0, 8'h01);
    rd_chk(A0, "R10 stored strobe still 0, restart");
  endtask

  task automatic t_hold;
    logic [7:0] last;
    pad_word[0] = 24'hFF_FF_FF;
    rd_chk(A0, "R11 setup");
    last = cpu_rdata;
    pad_word[0] = 24'h00_00_00;
    repeat (4) @(negedge clk);
    check("R11 hold without read", cpu_rdata, last);
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    pad_word[0] = 24'hB3_5A_C1;
    pad_word[1] = 24'h6E_17_F9;
    exp_idx[0] = 0; exp_idx[1] = 0; exp_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_port0_full();
    t_port1_full();
    t_strobe();
    t_other();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule